// File: doc/BRIEF.md
# Single-Precision Round and Pack Stage

This block is the last step of a single-precision floating-point datapath. An upstream unit (adder, multiplier or converter) hands it a sign, a biased exponent, a normalized 24-bit significand with its hidden bit, and three extra bits below the significand (guard, round, sticky). The block applies the selected rounding direction and renormalizes if the increment carries out. It then packs the 32-bit IEEE 754 word and raises the inexact, overflow and underflow flags.

Directed rounding is sign-aware. When a result overflows, the block returns either infinity or the largest finite magnitude, depending on the mode and the sign. A directed mode therefore never moves a value past infinity in the direction it forbids. The variant has no subnormal hardware, so any result below the normal exponent range is replaced by a zero carrying the result sign. All logic sits in front of one output register, so a result appears one clock after it is offered.

Top module: `fpr_round_stage`

## Requirements
- R1: `out_valid` equals `in_valid` delayed by one clock. Result and flags update only on cycles with `in_valid` high and otherwise hold. Synchronous reset clears every output to zero.
- R2: The full 3-bit mode field is decoded with this encoding: 0 nearest-even, 1 toward zero, 2 toward negative infinity, 3 toward positive infinity, 4 nearest with ties away from zero. Modes 0 and 4 must give different results on an exact tie.
- R3: In mode 0 the magnitude is incremented when guard is 1 and either round, sticky or the significand LSB is 1. A tie therefore rounds to an even LSB.
- R4: In mode 4 the magnitude is incremented whenever guard is 1.
- R5: Mode 3 increments the magnitude of positive results that have any nonzero extra bit, and mode 2 does the same for negative results. The opposite sign is truncated in each case.
- R6: Mode 1 always truncates. On overflow it returns the largest finite magnitude (exponent field 254, fraction all ones) with the result sign.
- R7: On overflow, mode 3 gives +infinity for positive results and the negative largest finite value for negative ones. Mode 2 gives −infinity for negative results and the positive largest finite value for positive ones.
- R8: On overflow, modes 0 and 4 return infinity (exponent field 255, fraction zero) with the result sign.
- R9: For a normal result, NX is 1 exactly when any of guard, round or sticky (bits 2, 1, 0 of `in_grs`) is 1. Whenever OF or UF is 1, NX is also 1.
- R10: A biased exponent of 0 or below, with a nonzero significand, gives a zero carrying the input sign, with UF and NX set. This test uses the exponent before rounding.
- R11: If the rounding increment carries out of a significand of all ones, the exponent rises by one and the fraction becomes zero. If the new exponent is 255 or more, the overflow rules apply.
- R12: Mode codes 5, 6 and 7 give a +0 result with all three flags clear, whatever the other inputs are.
- R13: An input whose hidden bit (`in_sig[23]`) is 0 is an exact zero. It gives a zero with the input sign and no flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand present this cycle |
| in_sign | input | 1 | Result sign |
| in_exp | input | 10 | Signed biased exponent, may exceed the normal range |
| in_sig | input | 24 | Significand with hidden bit at the top |
| in_grs | input | 3 | Guard, round, sticky (bit 2 down to bit 0) |
| in_rm | input | 3 | Rounding-mode code |
| out_valid | output | 1 | Result registered this cycle |
| out_result | output | 32 | Packed single-precision word |
| out_nx | output | 1 | Inexact flag |
| out_of | output | 1 | Overflow flag |
| out_uf | output | 1 | Underflow flag |

## Verification
The bound checker watches several rules on every cycle. It confirms that valid is delayed one clock and that OF or UF never appears without NX. It confirms that an underflow always produces a zero magnitude and that reserved mode codes give a quiet +0. It also confirms that no directed mode ever emits the infinity it forbids. The exact rounding decisions are shown only by the bench's scenarios, since they need computed expected words: ties to even versus away, sign-dependent increments, carry renormalization into the next exponent, and the choice between infinity and the largest finite value on overflow.

// File: rtl/fpr_pkg.sv
package fpr_pkg;

  localparam logic [2:0] RM_NEAR_EVEN = 3'd0;
  localparam logic [2:0] RM_TO_ZERO   = 3'd1;
  localparam logic [2:0] RM_TO_NEG    = 3'd2;
  localparam logic [2:0] RM_TO_POS    = 3'd3;
  localparam logic [2:0] RM_NEAR_MAX  = 3'd4;

  typedef enum logic [1:0] {
    OVF_INF    = 2'd0,
    OVF_MAXFIN = 2'd1
  } ovf_pick_e;

  typedef struct packed {
    logic nx;
    logic of;
    logic uf;
  } fpr_flags_t;

endpackage

// File: rtl/fpr_inc_decide.sv
module fpr_inc_decide
  import fpr_pkg::*;
(
  input  logic       rm_mode_i_sign,
  input  logic [2:0] rm_code,
  input  logic       lsb,
  input  logic [2:0] grs,
  output logic       inc,
  output logic       lossy,
  output logic       mode_ok,
  output ovf_pick_e  ovf_pick
);

  logic g_bit;
  logic rs_any;

  assign g_bit  = grs[2];
  assign rs_any = grs[1] | grs[0];
  assign lossy  = |grs;

  always_comb begin
    inc      = 1'b0;
    mode_ok  = 1'b1;
    ovf_pick = OVF_INF;
    case (rm_code)
      RM_NEAR_EVEN: begin
        inc      = g_bit & (rs_any | lsb);
        ovf_pick = OVF_INF;
      end
      RM_TO_ZERO: begin
        inc      = 1'b0;
        ovf_pick = OVF_MAXFIN;
      end
      RM_TO_NEG: begin
        inc      = rm_mode_i_sign & lossy;
        ovf_pick = rm_mode_i_sign ? OVF_INF : OVF_MAXFIN;
      end
      RM_TO_POS: begin
        inc      = ~rm_mode_i_sign & lossy;
        ovf_pick = rm_mode_i_sign ? OVF_MAXFIN : OVF_INF;
      end
      RM_NEAR_MAX: begin
        inc      = g_bit;
        ovf_pick = OVF_INF;
      end
      default: begin
        inc      = 1'b0;
        mode_ok  = 1'b0;
        ovf_pick = OVF_INF;
      end
    endcase
  end

endmodule

// File: rtl/fpr_sig_incr.sv
module fpr_sig_incr #(
  parameter int MAN_W    = 23,
  parameter int EXP_IN_W = 10
) (
  input  logic signed [EXP_IN_W-1:0] exp_in,
  input  logic [MAN_W:0]             sig_in,
  input  logic                       inc,
  output logic signed [EXP_IN_W:0]   exp_out,
  output logic [MAN_W-1:0]           frac_out
);

  localparam int SUM_W = MAN_W + 2;

  logic [SUM_W-1:0] sum;
  logic             carry;

  assign sum   = {1'b0, sig_in} + {{(SUM_W-1){1'b0}}, inc};
  assign carry = sum[SUM_W-1];

  always_comb begin
    if (carry) begin
      exp_out  = {exp_in[EXP_IN_W-1], exp_in} + {{EXP_IN_W{1'b0}}, 1'b1};
      frac_out = '0;
    end else begin
      exp_out  = {exp_in[EXP_IN_W-1], exp_in};
      frac_out = sum[MAN_W-1:0];
    end
  end

endmodule

// File: rtl/fpr_pack_select.sv
module fpr_pack_select
  import fpr_pkg::*;
#(
  parameter int EXP_W    = 8,
  parameter int MAN_W    = 23,
  parameter int EXP_IN_W = 10
) (
  input  logic                       sign,
  input  logic                       is_zero,
  input  logic signed [EXP_IN_W-1:0] pre_exp,
  input  logic signed [EXP_IN_W:0]   post_exp,
  input  logic [MAN_W-1:0]           frac,
  input  logic                       lossy,
  input  logic                       mode_ok,
  input  ovf_pick_e                  ovf_pick,
  output logic [EXP_W+MAN_W:0]       word,
  output fpr_flags_t                 flags
);

  localparam int WORD_W = EXP_W + MAN_W + 1;
  localparam logic signed [EXP_IN_W:0]   EXP_TOP  = (EXP_IN_W+1)'((1 << EXP_W) - 1);
  localparam logic signed [EXP_IN_W-1:0] EXP_ZERO = '0;
  localparam logic [EXP_W-1:0]           EF_INF   = '1;
  localparam logic [EXP_W-1:0]           EF_MAX   = EF_INF - 1'b1;

  logic tiny;
  logic huge;

  assign tiny = (pre_exp <= EXP_ZERO);
  assign huge = (post_exp >= EXP_TOP);

  always_comb begin
    word  = '0;
    flags = '0;
    if (!mode_ok) begin
      word  = '0;
      flags = '0;
    end else if (is_zero) begin
      word  = {sign, {(WORD_W-1){1'b0}}};
      flags = '0;
    end else if (tiny) begin
      word     = {sign, {(WORD_W-1){1'b0}}};
      flags.uf = 1'b1;
      flags.nx = 1'b1;
    end else if (huge) begin
      flags.of = 1'b1;
      flags.nx = 1'b1;
      if (ovf_pick == OVF_MAXFIN)
        word = {sign, EF_MAX, {MAN_W{1'b1}}};
      else
        word = {sign, EF_INF, {MAN_W{1'b0}}};
    end else begin
      word     = {sign, post_exp[EXP_W-1:0], frac};
      flags.nx = lossy;
    end
  end

endmodule

// File: rtl/fpr_round_stage.sv
module fpr_round_stage
  import fpr_pkg::*;
#(
  parameter int EXP_W    = 8,
  parameter int MAN_W    = 23,
  parameter int EXP_IN_W = EXP_W + 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       in_valid,
  input  logic                       in_sign,
  input  logic signed [EXP_IN_W-1:0] in_exp,
  input  logic [MAN_W:0]             in_sig,
  input  logic [2:0]                 in_grs,
  input  logic [2:0]                 in_rm,
  output logic                       out_valid,
  output logic [EXP_W+MAN_W:0]       out_result,
  output logic                       out_nx,
  output logic                       out_of,
  output logic                       out_uf
);

  localparam int WORD_W = EXP_W + MAN_W + 1;

  logic                     inc;
  logic                     lossy;
  logic                     mode_ok;
  ovf_pick_e                ovf_pick;
  logic signed [EXP_IN_W:0] post_exp;
  logic [MAN_W-1:0]         frac;
  logic [WORD_W-1:0]        word_c;
  fpr_flags_t               flags_c;
  logic                     is_zero;

  assign is_zero = ~in_sig[MAN_W];

  fpr_inc_decide u_decide (
    .rm_mode_i_sign (in_sign),
    .rm_code        (in_rm),
    .lsb            (in_sig[0]),
    .grs            (in_grs),
    .inc            (inc),
    .lossy          (lossy),
    .mode_ok        (mode_ok),
    .ovf_pick       (ovf_pick)
  );

  fpr_sig_incr #(
    .MAN_W    (MAN_W),
    .EXP_IN_W (EXP_IN_W)
  ) u_incr (
    .exp_in   (in_exp),
    .sig_in   (in_sig),
    .inc      (inc),
    .exp_out  (post_exp),
    .frac_out (frac)
  );

  fpr_pack_select #(
    .EXP_W    (EXP_W),
    .MAN_W    (MAN_W),
    .EXP_IN_W (EXP_IN_W)
  ) u_pack (
    .sign     (in_sign),
    .is_zero  (is_zero),
    .pre_exp  (in_exp),
    .post_exp (post_exp),
    .frac     (frac),
    .lossy    (lossy),
    .mode_ok  (mode_ok),
    .ovf_pick (ovf_pick),
    .word     (word_c),
    .flags    (flags_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_nx     <= 1'b0;
      out_of     <= 1'b0;
      out_uf     <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_result <= word_c;
        out_nx     <= flags_c.nx;
        out_of     <= flags_c.of;
        out_uf     <= flags_c.uf;
      end
    end
  end

endmodule

// File: rtl/fpr_round_stage_chk.sv
module fpr_round_stage_chk #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 in_valid,
  input logic                 in_sign,
  input logic [2:0]           in_rm,
  input logic                 out_valid,
  input logic [EXP_W+MAN_W:0] out_result,
  input logic                 out_nx,
  input logic                 out_of,
  input logic                 out_uf
);

  localparam int WORD_W = EXP_W + MAN_W + 1;
  localparam logic [WORD_W-1:0] POS_INF = {1'b0, {EXP_W{1'b1}}, {MAN_W{1'b0}}};
  localparam logic [WORD_W-1:0] NEG_INF = {1'b1, {EXP_W{1'b1}}, {MAN_W{1'b0}}};

  AST_VALID_RISE: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R1
  AST_VALID_FALL: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid); // R1
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_result)); // R1
  AST_EXC_HAS_NX: assert property (@(posedge clk) disable iff (rst)
    (out_valid && (out_of || out_uf)) |-> out_nx); // R9
  AST_UF_IS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_uf) |-> (out_result[WORD_W-2:0] == '0)); // R10
  AST_RTZ_NO_INF: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_rm == 3'd1) |=> (out_result != POS_INF && out_result != NEG_INF)); // R6
  AST_UP_NO_NEG_INF: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_rm == 3'd3) |=> (out_result != NEG_INF)); // R7
  AST_DOWN_NO_POS_INF: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_rm == 3'd2) |=> (out_result != POS_INF)); // R7
  AST_RESERVED_QUIET: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_rm >= 3'd5) |=> (out_result == '0 && !out_nx && !out_of && !out_uf)); // R12
  AST_SIGN_KEPT: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_rm <= 3'd4) |=> (out_result[WORD_W-1] == $past(in_sign))); // R8

endmodule

bind fpr_round_stage fpr_round_stage_chk #(
  .EXP_W (EXP_W),
  .MAN_W (MAN_W)
) chk_i (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .in_sign    (in_sign),
  .in_rm      (in_rm),
  .out_valid  (out_valid),
  .out_result (out_result),
  .out_nx     (out_nx),
  .out_of     (out_of),
  .out_uf     (out_uf)
);

// File: tb/fpr_round_stage_tb_top.sv
`timescale 1ns/1ps
module fpr_round_stage_tb_top;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              in_valid = 1'b0;
  logic              in_sign = 1'b0;
  logic signed [9:0] in_exp = '0;
  logic [23:0]       in_sig = '0;
  logic [2:0]        in_grs = '0;
  logic [2:0]        in_rm = '0;
  logic              out_valid;
  logic [31:0]       out_result;
  logic              out_nx;
  logic              out_of;
  logic              out_uf;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  fpr_round_stage dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sign(in_sign),
    .in_exp(in_exp), .in_sig(in_sig), .in_grs(in_grs), .in_rm(in_rm),
    .out_valid(out_valid), .out_result(out_result),
    .out_nx(out_nx), .out_of(out_of), .out_uf(out_uf)
  );

  task automatic check(string tag, logic [31:0] exp_word, logic [2:0] exp_f);
    total++;
    if (out_valid !== 1'b1 || out_result !== exp_word || {out_nx, out_of, out_uf} !== exp_f) begin
      bad++;
      $display("FAIL %s: got v=%b word=%08h nx/of/uf=%b, want v=1 word=%08h nx/of/uf=%b",
               tag, out_valid, out_result, {out_nx, out_of, out_uf}, exp_word, exp_f);
    end
  endtask

  task automatic apply(logic s, int e, logic [23:0] m, logic [2:0] g, logic [2:0] rm);
    @(negedge clk);
    in_valid = 1'b1; in_sign = s; in_exp = 10'(e); in_sig = m; in_grs = g; in_rm = rm;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic run(string tag, logic s, int e, logic [23:0] m, logic [2:0] g,
                     logic [2:0] rm, logic [31:0] w, logic [2:0] f);
    apply(s, e, m, g, rm);
    check(tag, w, f);
  endtask

  task automatic t_reset();
    total++;
    if (out_valid !== 1'b0 || out_result !== 32'h0 || {out_nx, out_of, out_uf} !== 3'b000) begin
      bad++;
      $display("FAIL R1 reset: got v=%b word=%08h flags=%b, want all zero",
               out_valid, out_result, {out_nx, out_of, out_uf});
    end
  endtask

  task automatic t_nearest();
    run("R3 tie even keeps", 0, 127, 24'h800000, 3'b100, 3'd0, 32'h3f800000, 3'b100);
    run("R3 tie odd rounds up", 0, 127, 24'h800001, 3'b100, 3'd0, 32'h3f800002, 3'b100);
    run("R3 above half", 1, 127, 24'h800000, 3'b101, 3'd0, 32'hbf800001, 3'b100);
    run("R4 R2 tie away", 0, 127, 24'h800000, 3'b100, 3'd4, 32'h3f800001, 3'b100);
    run("R4 below half", 0, 127, 24'h800000, 3'b011, 3'd4, 32'h3f800000, 3'b100);
  endtask

  task automatic t_directed();
    run("R5 up positive", 0, 127, 24'h800000, 3'b001, 3'd3, 32'h3f800001, 3'b100);
    run("R5 up negative", 1, 127, 24'h800000, 3'b001, 3'd3, 32'hbf800000, 3'b100);
    run("R5 down negative", 1, 127, 24'h800000, 3'b001, 3'd2, 32'hbf800001, 3'b100);
    run("R5 down positive", 0, 127, 24'h800000, 3'b001, 3'd2, 32'h3f800000, 3'b100);
    run("R6 toward zero truncates", 0, 127, 24'h800000, 3'b111, 3'd1, 32'h3f800000, 3'b100);
    run("R9 exact no NX", 0, 127, 24'h800000, 3'b000, 3'd0, 32'h3f800000, 3'b000);
  endtask

  task automatic t_carry();
    run("R11 carry renormalizes", 0, 127, 24'hffffff, 3'b110, 3'd0, 32'h40000000, 3'b100);
    run("R11 carry into overflow", 0, 254, 24'hffffff, 3'b100, 3'd0, 32'h7f800000, 3'b110);
    run("R11 up carry overflow", 0, 254, 24'hffffff, 3'b001, 3'd3, 32'h7f800000, 3'b110);
    run("R6 toward zero at top no OF", 0, 254, 24'hffffff, 3'b111, 3'd1, 32'h7f7fffff, 3'b100);
  endtask

  task automatic t_overflow();
    run("R8 even neg inf", 1, 300, 24'h800000, 3'b000, 3'd0, 32'hff800000, 3'b110);
    run("R8 away pos inf", 0, 300, 24'h800000, 3'b000, 3'd4, 32'h7f800000, 3'b110);
    run("R6 zero neg max", 1, 300, 24'h800000, 3'b000, 3'd1, 32'hff7fffff, 3'b110);
    run("R6 zero pos max", 0, 255, 24'h800000, 3'b000, 3'd1, 32'h7f7fffff, 3'b110);
    run("R7 up neg max", 1, 300, 24'h800000, 3'b000, 3'd3, 32'hff7fffff, 3'b110);
    run("R7 up pos inf", 0, 300, 24'h800000, 3'b000, 3'd3, 32'h7f800000, 3'b110);
    run("R7 down pos max", 0, 300, 24'h800000, 3'b000, 3'd2, 32'h7f7fffff, 3'b110);
    run("R7 down neg inf", 1, 300, 24'h800000, 3'b000, 3'd2, 32'hff800000, 3'b110);
  endtask

  task automatic t_underflow();
    run("R10 exp zero neg", 1, 0, 24'h900000, 3'b000, 3'd0, 32'h80000000, 3'b101);
    run("R10 exp negative pos", 0, -5, 24'hffffff, 3'b111, 3'd3, 32'h00000000, 3'b101);
    run("R13 exact zero", 1, 0, 24'h000000, 3'b000, 3'd0, 32'h80000000, 3'b000);
    run("R13 zero big exp", 0, 300, 24'h7fffff, 3'b111, 3'd3, 32'h00000000, 3'b000);
  endtask

  task automatic t_reserved();
    for (int c = 5; c < 8; c++)
      run("R12 reserved code", 1, 300, 24'hffffff, 3'b111, 3'(c), 32'h00000000, 3'b000);
  endtask

  task automatic t_idle_hold();
    apply(0, 128, 24'hc00000, 3'b000, 3'd0);
    check("R1 load", 32'h40400000, 3'b000);
    @(negedge clk);
    in_sign = 1; in_exp = 10'sd300; in_rm = 3'd1;
    @(negedge clk);
    total++;
    if (out_valid !== 1'b0 || out_result !== 32'h40400000 || {out_nx, out_of, out_uf} !== 3'b000) begin
      bad++;
      $display("FAIL R1 idle hold: got v=%b word=%08h flags=%b, want v=0 word=40400000 flags=000",
               out_valid, out_result, {out_nx, out_of, out_uf});
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_nearest();
    t_directed();
    t_carry();
    t_overflow();
    t_underflow();
    t_reserved();
    t_idle_hold();
    @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: got timeout, want completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule